// File: doc/BRIEF.md
# Time-Multiplexed Pixel Output Formatter

This block sits at the end of a display pipeline, after dithering. It takes one pixel per accepted handshake and drives it onto a narrow parallel display bus, spreading it over one, two or three bus beats. In the three-beat pair format, two pixels are packed into the same three beats. The beat count, the number of bits in each beat and the bus width are runtime inputs. They are captured at the pixel boundary. When multiplexing is off, the pixel is sent in one beat on a wide bus. The width of that bus comes from a separate lane-count field.

Each colour component is cut down to its 8 most significant bits. The three components are packed red, green, blue into a 24-bit word. In multiplexed mode, that word (or the two words of a pair) forms a bit stream. Each beat takes a slice from the stream, starting at the most significant bit. The slice is placed at the top of the selected bus lanes. Any extra channel that travels with the pixel is dropped.

Top module: `tdm_pixel_packer`

## Requirements
- R1: Only the red, green and blue components are used; the auxiliary field `pix_data[AUX_W+3*COMP_W-1:3*COMP_W]` has no effect on any output. Each component (red at the top, blue at the bottom of `pix_data`) is cut to its 8 most significant bits.
- R2: With `mux_en`=1, `cyc_fmt` selects the beats per pixel: 0 gives one beat, 1 gives two beats, 2 gives three beats, and 3 gives three beats shared by a pixel pair. `bus_de` is high on exactly those beats, starting the cycle after the pixel is accepted.
- R3: `bus_sel` selects the bus width: 0 is 8 lanes, 1 is 9, 2 is 12 and 3 is 16. Each beat's bits are placed from lane width-1 downward. All other lanes of `bus_data`, including lanes 16 to 23, are zero.
- R4: Beats take consecutive bits of the stream {R[7:0],G[7:0],B[7:0]}, starting at the most significant bit. The counts come from `bits_c0`, `bits_c1` and `bits_c2` in beat order. Stream positions past the end of the stream give zero bits.
- R5: A per-beat bit count larger than the selected bus width is treated as equal to that width.
- R6: With `cyc_fmt`=3, the stream is the first pixel's 24 bits followed by the second pixel's 24 bits. Beat 0 is sent the cycle after the first pixel is accepted. `pix_ready` then stays high until the second pixel is accepted, and `bus_de` is low while waiting for it. Beats 1 and 2 follow on consecutive cycles.
- R7: `pix_ready` is low while the remaining beats of a non-paired pixel are being sent, and high at every pixel boundary.
- R8: All configuration inputs are captured when a pixel (the first pixel of a pair) is accepted. Changes made while beats are outstanding do not alter those beats.
- R9: With `mux_en`=0, each pixel is one beat, right-justified on `bus_data`, with the lane count taken from `lanes_sel`: 0 gives 12 lanes (4:4:4), 1 gives 16 (5:6:5), 2 gives 18 (6:6:6), and 3 to 7 give 24 (8:8:8). Each component keeps its top bits. Unused upper lanes are zero.
- R10: After reset, `bus_de` is 0, `bus_data` is 0 and `pix_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Input pixel valid |
| pix_ready | output | 1 | Block can take a pixel this cycle |
| pix_data | input | AUX_W+3*COMP_W | {aux, red, green, blue} |
| mux_en | input | 1 | 1 = time-multiplexed output, 0 = single wide beat |
| cyc_fmt | input | 2 | Beat format (one, two, three, paired three) |
| bus_sel | input | 2 | Multiplexed bus width select |
| bits_c0 | input | 5 | Bits carried in beat 0 |
| bits_c1 | input | 5 | Bits carried in beat 1 |
| bits_c2 | input | 5 | Bits carried in beat 2 |
| lanes_sel | input | 3 | Bus lane count when multiplexing is off |
| bus_data | output | 24 | Display data lanes |
| bus_de | output | 1 | Data-enable, high on each sent beat |

## Verification
The bench builds the block with its default parameters: 10-bit components and an 8-bit auxiliary field. This means truncation to the top bits actually discards data, and random auxiliary bits show whether that channel leaks into the output. A behavioural stream model compares every cycle across all four bus widths, all lane counts and all beat formats. It covers bit counts above the bus width, counts that run past the end of the stream, stalls in the middle of a pair, and a final stretch where every configuration field is changed at random on every cycle.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    localparam int WORD_W   = 24;
    localparam int STREAM_W = 2 * WORD_W;
    localparam int BUS_MAX  = 16;
    localparam int OUT_W    = 24;
    localparam int CNT_W    = 5;

    typedef enum logic [1:0] {
        FMT_ONE   = 2'd0,
        FMT_TWO   = 2'd1,
        FMT_THREE = 2'd2,
        FMT_PAIR  = 2'd3
    } cyc_fmt_e;

    typedef struct packed {
        logic [1:0]          ph;
        logic                need_b;
        logic [STREAM_W-1:0] sr;
        logic [1:0]          fmt;
        logic [1:0]          bsel;
        logic [CNT_W-1:0]    n0e;
        logic [CNT_W-1:0]    n1;
        logic [CNT_W-1:0]    n2;
        logic [OUT_W-1:0]    out_data;
        logic                out_de;
        logic                out_tdm;
    } pack_state_t;

    function automatic logic [CNT_W-1:0] bus_width(input logic [1:0] sel);
        case (sel)
            2'd0:    return CNT_W'(8);
            2'd1:    return CNT_W'(9);
            2'd2:    return CNT_W'(12);
            default: return CNT_W'(16);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] clamp_bits(input logic [CNT_W-1:0] n,
                                                    input logic [1:0] sel);
        logic [CNT_W-1:0] w;
        w = bus_width(sel);
        return (n > w) ? w : n;
    endfunction

endpackage

// File: rtl/tdm_comp_trunc.sv
module tdm_comp_trunc #(
    parameter int COMP_W = 10,
    parameter int KEEP_W = 8
) (
    input  logic [COMP_W-1:0] comp,
    output logic [KEEP_W-1:0] kept
);
    generate
        if (COMP_W > KEEP_W) begin : g_cut
            logic unused_low;
            assign unused_low = ^comp[COMP_W-KEEP_W-1:0];
            assign kept = comp[COMP_W-1 -: KEEP_W];
        end else if (COMP_W == KEEP_W) begin : g_same
            assign kept = comp;
        end else begin : g_pad
            assign kept = {comp, {(KEEP_W-COMP_W){1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/tdm_bypass_fmt.sv
module tdm_bypass_fmt
    import tdm_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [2:0]        lanes_sel,
    output logic [OUT_W-1:0]  wide
);
    logic [7:0] r, g, b;

    always_comb begin
        r = word[23:16];
        g = word[15:8];
        b = word[7:0];
        case (lanes_sel)
            3'd0:    wide = {12'b0, r[7:4], g[7:4], b[7:4]};
            3'd1:    wide = {8'b0,  r[7:3], g[7:2], b[7:3]};
            3'd2:    wide = {6'b0,  r[7:2], g[7:2], b[7:2]};
            default: wide = word;
        endcase
    end
endmodule

// File: rtl/tdm_beat_slicer.sv
module tdm_beat_slicer
    import tdm_pkg::*;
(
    input  logic [STREAM_W-1:0] src,
    input  logic [CNT_W-1:0]    nbits,
    input  logic [1:0]          bsel,
    output logic [OUT_W-1:0]    beat,
    output logic [CNT_W-1:0]    used
);
    logic [CNT_W-1:0]   bw;
    logic [BUS_MAX-1:0] head;
    logic [BUS_MAX-1:0] keep;
    logic               unused_tail;

    assign unused_tail = ^src[STREAM_W-BUS_MAX-1:0];

    always_comb begin
        bw   = bus_width(bsel);
        used = clamp_bits(nbits, bsel);
        head = src[STREAM_W-1 -: BUS_MAX];
        keep = head & ~({BUS_MAX{1'b1}} >> used);
        beat = {{(OUT_W-BUS_MAX){1'b0}}, keep >> (CNT_W'(BUS_MAX) - bw)};
    end

    always_comb begin
        if (bw != 0) begin
            AST_SLICE_FITS: assert ((beat >> bw) == '0); // R3
        end
    end
endmodule

// File: rtl/tdm_pixel_packer.sv
module tdm_pixel_packer
    import tdm_pkg::*;
#(
    parameter int COMP_W = 10,
    parameter int AUX_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pix_valid,
    output logic                      pix_ready,
    input  logic [AUX_W+3*COMP_W-1:0] pix_data,
    input  logic                      mux_en,
    input  logic [1:0]                cyc_fmt,
    input  logic [1:0]                bus_sel,
    input  logic [4:0]                bits_c0,
    input  logic [4:0]                bits_c1,
    input  logic [4:0]                bits_c2,
    input  logic [2:0]                lanes_sel,
    output logic [23:0]               bus_data,
    output logic                      bus_de
);
    localparam int RGB_W  = 3 * COMP_W;
    localparam int KEEP_W = WORD_W / 3;

    pack_state_t q, d;

    logic [WORD_W-1:0]   word;
    logic [OUT_W-1:0]    wide;
    logic [STREAM_W-1:0] merged;
    logic [STREAM_W-1:0] sl_src;
    logic [CNT_W-1:0]    sl_n;
    logic [1:0]          sl_bsel;
    logic [OUT_W-1:0]    sl_beat;
    logic [CNT_W-1:0]    sl_used;
    logic                accept;
    logic                unused_aux;

    assign unused_aux = ^pix_data[AUX_W+RGB_W-1:RGB_W];

    // channel 0 = blue, 1 = green, 2 = red
    for (genvar ch = 0; ch < 3; ch++) begin : g_chan
        tdm_comp_trunc #(
            .COMP_W (COMP_W),
            .KEEP_W (KEEP_W)
        ) u_trunc (
            .comp (pix_data[ch*COMP_W +: COMP_W]),
            .kept (word[ch*KEEP_W +: KEEP_W])
        );
    end

    tdm_bypass_fmt u_bypass (
        .word      (word),
        .lanes_sel (lanes_sel),
        .wide      (wide)
    );

    tdm_beat_slicer u_slice (
        .src   (sl_src),
        .nbits (sl_n),
        .bsel  (sl_bsel),
        .beat  (sl_beat),
        .used  (sl_used)
    );

    assign pix_ready = (q.ph == 2'd0) || q.need_b;
    assign accept    = pix_valid && pix_ready;
    assign merged    = q.sr | ({{WORD_W{1'b0}}, word} << q.n0e);

    // slicer source selection
    always_comb begin
        case (q.ph)
            2'd0: begin
                sl_src  = {word, {WORD_W{1'b0}}};
                sl_n    = bits_c0;
                sl_bsel = bus_sel;
            end
            2'd1: begin
                sl_src  = q.need_b ? merged : q.sr;
                sl_n    = q.n1;
                sl_bsel = q.bsel;
            end
            default: begin
                sl_src  = q.sr;
                sl_n    = q.n2;
                sl_bsel = q.bsel;
            end
        endcase
    end

    // next-state computation
    always_comb begin
        d          = q;
        d.out_de   = 1'b0;
        d.out_tdm  = 1'b0;
        d.out_data = '0;
        case (q.ph)
            2'd0: begin
                if (accept) begin
                    d.out_de = 1'b1;
                    if (!mux_en) begin
                        d.out_data = wide;
                    end else begin
                        d.out_tdm  = 1'b1;
                        d.out_data = sl_beat;
                        d.sr       = sl_src << sl_used;
                        d.fmt      = cyc_fmt;
                        d.bsel     = bus_sel;
                        d.n0e      = sl_used;
                        d.n1       = bits_c1;
                        d.n2       = bits_c2;
                        d.need_b   = (cyc_fmt == FMT_PAIR);
                        d.ph       = (cyc_fmt == FMT_ONE) ? 2'd0 : 2'd1;
                    end
                end
            end
            2'd1: begin
                if (!q.need_b || pix_valid) begin
                    d.out_de   = 1'b1;
                    d.out_tdm  = 1'b1;
                    d.out_data = sl_beat;
                    d.sr       = sl_src << sl_used;
                    d.need_b   = 1'b0;
                    d.ph       = (q.fmt == FMT_ONE || q.fmt == FMT_TWO) ? 2'd0 : 2'd2;
                end
            end
            default: begin
                d.out_de   = 1'b1;
                d.out_tdm  = 1'b1;
                d.out_data = sl_beat;
                d.sr       = sl_src << sl_used;
                d.ph       = 2'd0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign bus_data = q.out_data;
    assign bus_de   = q.out_de;

    AST_DE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> bus_de); // R2

    AST_READY_LOW_MIDPIX: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mux_en && (cyc_fmt == FMT_TWO || cyc_fmt == FMT_THREE) && !q.need_b)
        |=> !pix_ready); // R7

    AST_PAIR_WAITS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mux_en && cyc_fmt == FMT_PAIR && q.ph == 2'd0) |=> pix_ready); // R6

    AST_IDLE_NO_DE: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_ready && !pix_valid) |=> !bus_de); // R6

    AST_TDM_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        q.out_tdm |-> (bus_data[23:16] == 8'd0)); // R3

    AST_READY_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> (pix_ready && !bus_de)); // R10

endmodule

// File: tb/tdm_pixel_packer_test.sv
module tdm_pixel_packer_test;
    localparam int COMP_W = 10;
    localparam int AUX_W  = 8;
    localparam int IN_W   = AUX_W + 3 * COMP_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pix_valid = 1'b0;
    logic            pix_ready;
    logic [IN_W-1:0] pix_data = '0;
    logic            mux_en = 1'b0;
    logic [1:0]      cyc_fmt = '0;
    logic [1:0]      bus_sel = '0;
    logic [4:0]      bits_c0 = '0, bits_c1 = '0, bits_c2 = '0;
    logic [2:0]      lanes_sel = '0;
    logic [23:0]     bus_data;
    logic            bus_de;

    always #4 clk = ~clk;

    tdm_pixel_packer #(.COMP_W(COMP_W), .AUX_W(AUX_W)) uut (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_data(pix_data), .mux_en(mux_en), .cyc_fmt(cyc_fmt), .bus_sel(bus_sel),
        .bits_c0(bits_c0), .bits_c1(bits_c1), .bits_c2(bits_c2),
        .lanes_sel(lanes_sel), .bus_data(bus_data), .bus_de(bus_de)
    );

    int checks = 0;
    int fails  = 0;
    string cur_req = "R10";

    // next-cycle drive values
    logic            nv = 0;
    logic [IN_W-1:0] nd = '0;
    logic            n_en = 0;
    logic [1:0]      n_fmt = 0, n_bsel = 0;
    int              n_c[3] = '{0, 0, 0};
    logic [2:0]      n_lanes = 0;

    // reference model state
    logic [24:0] beatq[$];
    logic        pend = 0;
    logic [23:0] pa = '0;
    int          m_c[3];
    int          m_bw;
    logic        exp_de = 0;
    logic [23:0] exp_data = '0;

    function automatic int width_of(input logic [1:0] s);
        int t[4] = '{8, 9, 12, 16};
        return t[s];
    endfunction

    function automatic logic [23:0] to_word(input logic [IN_W-1:0] p);
        return {p[3*COMP_W-1 -: 8], p[2*COMP_W-1 -: 8], p[COMP_W-1 -: 8]};
    endfunction

    function automatic logic [23:0] mk_beat(input logic [47:0] s, input int pos,
                                            input int n, input int bw);
        logic [23:0] r = '0;
        for (int i = 0; i < n; i++)
            if (pos + i < 48) r[bw-1-i] = s[47-pos-i];
        return r;
    endfunction

    function automatic logic [23:0] bypass_of(input logic [23:0] w, input logic [2:0] ls);
        int kr, kg, kb;
        logic [23:0] o;
        case (ls)
            3'd0:    begin kr = 4; kg = 4; kb = 4; end
            3'd1:    begin kr = 5; kg = 6; kb = 5; end
            3'd2:    begin kr = 6; kg = 6; kb = 6; end
            default: begin kr = 8; kg = 8; kb = 8; end
        endcase
        o = (24'(w[23:16]) >> (8 - kr)) << (kg + kb);
        o = o | ((24'(w[15:8]) >> (8 - kg)) << kb);
        o = o | (24'(w[7:0]) >> (8 - kb));
        return o;
    endfunction

    task automatic tick();
        bit          rdy_exp;
        logic [23:0] w;
        logic [47:0] st;
        int          pos;
        @(negedge clk);
        checks++;
        if ({bus_de, bus_data} !== {exp_de, exp_data}) begin
            fails++;
            $display("FAIL %s bus de/data got %b/%h exp %b/%h", cur_req,
                     bus_de, bus_data, exp_de, exp_data);
        end
        rdy_exp = (beatq.size() == 0);
        checks++;
        if (pix_ready !== rdy_exp) begin
            fails++;
            $display("FAIL %s R7 pix_ready got %b exp %b", cur_req, pix_ready, rdy_exp);
        end
        pix_valid = nv; pix_data = nd; mux_en = n_en; cyc_fmt = n_fmt;
        bus_sel = n_bsel; bits_c0 = 5'(n_c[0]); bits_c1 = 5'(n_c[1]);
        bits_c2 = 5'(n_c[2]); lanes_sel = n_lanes;
        w = to_word(nd);
        exp_de = 1'b0; exp_data = '0;
        if (beatq.size() != 0) begin
            {exp_de, exp_data} = beatq.pop_front();
        end else if (pend) begin
            if (nv) begin
                st  = {pa, w};
                pos = m_c[0];
                exp_de = 1'b1;
                exp_data = mk_beat(st, pos, m_c[1], m_bw);
                pos += m_c[1];
                beatq.push_back({1'b1, mk_beat(st, pos, m_c[2], m_bw)});
                pend = 0;
            end
        end else if (nv) begin
            exp_de = 1'b1;
            if (!n_en) begin
                exp_data = bypass_of(w, n_lanes);
            end else begin
                m_bw = width_of(n_bsel);
                for (int k = 0; k < 3; k++) m_c[k] = (n_c[k] > m_bw) ? m_bw : n_c[k];
                st = {w, 24'b0};
                exp_data = mk_beat(st, 0, m_c[0], m_bw);
                if (n_fmt == 2'd3) begin
                    pend = 1; pa = w;
                end else begin
                    pos = m_c[0];
                    for (int k = 1; k <= int'(n_fmt); k++) begin
                        beatq.push_back({1'b1, mk_beat(st, pos, m_c[k], m_bw)});
                        pos += m_c[k];
                    end
                end
            end
        end
    endtask

    task automatic cfg(input string req, input logic en, input logic [1:0] f,
                       input logic [1:0] bs, input int c0, input int c1, input int c2,
                       input logic [2:0] ls);
        cur_req = req; n_en = en; n_fmt = f; n_bsel = bs;
        n_c[0] = c0; n_c[1] = c1; n_c[2] = c2; n_lanes = ls;
    endtask

    task automatic run(input int cycles, input int vprob, input bit randcfg);
        for (int i = 0; i < cycles; i++) begin
            nv = (($urandom % 100) < vprob);
            nd = {$urandom, $urandom};
            if (randcfg) begin
                n_en = 1'($urandom); n_fmt = 2'($urandom); n_bsel = 2'($urandom);
                n_c[0] = $urandom % 32; n_c[1] = $urandom % 32; n_c[2] = $urandom % 32;
                n_lanes = 3'($urandom);
            end
            tick();
        end
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        cur_req = "R10"; nv = 0;
        tick(); tick();
        // R9 R1 bypass, each lane count
        for (int ls = 0; ls < 8; ls++) begin
            cfg("R9 R1 bypass", 1'b0, 2'd0, 2'd0, 8, 8, 8, 3'(ls));
            run(20, 80, 1'b0);
        end
        // R2 R3 R4 one beat on 16 lanes
        cfg("R2 R3 R4 one-beat", 1'b1, 2'd0, 2'd3, 16, 0, 0, 3'd0);
        run(60, 70, 1'b0);
        // R2 R4 two beats on 12 lanes
        cfg("R2 R4 two-beat", 1'b1, 2'd1, 2'd2, 12, 12, 0, 3'd0);
        run(80, 70, 1'b0);
        // R2 R3 three beats on 8 lanes
        cfg("R2 R3 three-beat 8", 1'b1, 2'd2, 2'd0, 8, 8, 8, 3'd0);
        run(80, 90, 1'b0);
        // R4 stream overrun on 9 lanes gives zero tail
        cfg("R4 three-beat 9 tail", 1'b1, 2'd2, 2'd1, 9, 9, 9, 3'd0);
        run(80, 90, 1'b0);
        cfg("R4 uneven counts", 1'b1, 2'd2, 2'd2, 5, 10, 12, 3'd0);
        run(80, 60, 1'b0);
        // R5 clamp
        cfg("R5 clamp 8", 1'b1, 2'd2, 2'd0, 20, 31, 9, 3'd0);
        run(80, 80, 1'b0);
        cfg("R5 clamp 12", 1'b1, 2'd1, 2'd2, 13, 16, 0, 3'd0);
        run(60, 80, 1'b0);
        // R6 pairs
        cfg("R6 pair 16", 1'b1, 2'd3, 2'd3, 16, 16, 16, 3'd0);
        run(120, 50, 1'b0);
        cfg("R6 pair 12", 1'b1, 2'd3, 2'd2, 12, 12, 12, 3'd0);
        run(120, 90, 1'b0);
        // R8 configuration changing every cycle
        cur_req = "R8 random config";
        run(1500, 70, 1'b1);
        cfg("R7 drain", 1'b0, 2'd0, 2'd0, 0, 0, 0, 3'd0);
        run(6, 0, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule